// File: doc/BRIEF.md
# OR-Combining Auxiliary Signal Crossbar

This block routes a wide set of single-bit event and trip signals to eight auxiliary outputs that feed a downstream programmable logic fabric. The sources are arranged as thirty-two groups with four candidate signals each. For every output, each group has its own enable bit and its own 2-bit choice of candidate. Each output is the OR of the chosen candidates of all enabled groups, and it can then be inverted.

Configuration lives in per-output registers that are loaded through a simple write port (address, data, write enable). A per-output clear strobe wipes the group enables and candidate choices of that output. The path from the sources to the outputs is purely combinational, so a selected source shows up on its output in the same cycle. Candidate slots listed in the `RSVD_MASK` parameter are forced to 0 before selection.

Top module: `aux_xbar`

## Requirements
- R1: After synchronous reset, all enables, selections and invert bits are 0, and every output is 0 whatever the sources do.
- R2: Register index 0 of an output holds its enable mask. Bit g of the written data enables group g for that output.
- R3: Register indices 1 and 2 hold the candidate choices for groups 0–15 and 16–31. Group g uses bits [2*(g%16)+1 : 2*(g%16)] of its word. Candidate c of group g is source bit `src_i[4*g+c]`.
- R4: Each output is the OR of the chosen candidates of all of its enabled groups.
- R5: A disabled group has no effect on the output, whatever its sources or its candidate choice.
- R6: Bit 0 of register index 3 is the output's invert control. When it is set, the output is the complement of the OR result.
- R7: With no group enabled, the OR result is 0, so the output equals its invert bit.
- R8: A high `clr_i[o]` for one cycle sets every enable and candidate choice of output o to 0. Its invert bit is left unchanged.
- R9: When `clr_i[o]` and a write to output o occur in the same cycle, the clear wins and the write is dropped. A write to a different output in that cycle still takes effect.
- R10: Reserved source slots (the default is bits 79 and 87, which are group 19 candidate 3 and group 21 candidate 3) read as 0 and never assert the OR result.
- R11: A change on a selected, enabled source reaches the output in the same cycle, with no register stage.
- R12: The write address is {output index[2:0], register index[1:0]}. A write or clear touches only the addressed output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | {output index, register index} |
| cfg_wdata_i | input | 32 | Configuration write data |
| clr_i | input | 8 | Per-output clear of enables and choices |
| src_i | input | 128 | Source signals, bit 4*g+c = group g candidate c |
| aux_o | output | 8 | Auxiliary outputs |

## Verification
A single enabled group is driven on its chosen candidate and then on a neighbouring unchosen candidate. This separates correct candidate decoding from an off-by-one in the select field. Two enabled groups, one in each select word, are driven alone, together and not at all. This shows a true OR and not a priority or last-writer pick, and a disabled group with active sources proves that masking works. Inverted and unconfigured outputs, a reserved slot against its live neighbour, and a clear that collides with a write show the polarity, tie-off and priority rules.

// File: rtl/axb_pkg.sv
package axb_pkg;

    // Candidates per group; the select code of a group is SEL_W bits wide.
    localparam int unsigned CAND_N = 4;
    localparam int unsigned SEL_W  = $clog2(CAND_N);

    // Number of data words needed to hold all select codes of one output.
    function automatic int unsigned sel_words(input int unsigned grp_n, input int unsigned dw);
        return (grp_n * SEL_W + dw - 1) / dw;
    endfunction

endpackage

// File: rtl/axb_cfg_bank.sv
// Configuration registers of one auxiliary output.
// Register index 0: enable mask; 1..SELW: select words; SELW+1: invert (bit 0).
module axb_cfg_bank
    import axb_pkg::*;
#(
    parameter int unsigned GRP_N = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned RAW   = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   wr_i,
    input  logic [RAW-1:0]         reg_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic                   clr_i,
    output logic [GRP_N-1:0]       en_o,
    output logic [GRP_N*SEL_W-1:0] sel_o,
    output logic                   inv_o
);

    localparam int unsigned SELW    = sel_words(GRP_N, DW);
    localparam int unsigned INV_IDX = SELW + 1;
    localparam int unsigned SEL_TOT = GRP_N * SEL_W;

    typedef struct packed {
        logic [GRP_N-1:0]   en;
        logic [SEL_TOT-1:0] sel;
        logic               inv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (clr_i) begin
            cfg_d.en  = '0;
            cfg_d.sel = '0;
        end else if (wr_i) begin
            if (int'(reg_i) == 0) begin
                cfg_d.en = wdata_i[GRP_N-1:0];
            end
            for (int k = 0; k < int'(SELW); k++) begin
                if (int'(reg_i) == k + 1) begin
                    cfg_d.sel[k*DW +: DW] = wdata_i;
                end
            end
            if (int'(reg_i) == int'(INV_IDX)) begin
                cfg_d.inv = wdata_i[0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o  = cfg_q.en;
    assign sel_o = cfg_q.sel;
    assign inv_o = cfg_q.inv;

    // R8: a clear wipes enables and choices but keeps polarity.
    p_clear_wipes_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (en_o == '0) && (sel_o == '0) && (inv_o == $past(inv_o)));

    // R9: a write colliding with a clear leaves no trace.
    p_clear_beats_write_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && wr_i) |=> (en_o == '0) && (inv_o == $past(inv_o)));

    // R2: an enable write without a clear lands in the enable mask.
    p_en_write_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && !clr_i && reg_i == '0) |=> (en_o == $past(wdata_i[GRP_N-1:0])));

    // R12: no access means no configuration change.
    p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_i && !clr_i) |=> ($stable(en_o) && $stable(sel_o) && $stable(inv_o)));

endmodule

// File: rtl/axb_merge.sv
// Combinational per-group candidate pick, masked OR and polarity for one output.
module axb_merge
    import axb_pkg::*;
#(
    parameter int unsigned GRP_N = 32
) (
    input  logic [GRP_N*CAND_N-1:0] src_i,
    input  logic [GRP_N-1:0]        en_i,
    input  logic [GRP_N*SEL_W-1:0]  sel_i,
    input  logic                    inv_i,
    output logic                    aux_o
);

    logic [GRP_N-1:0] pick;
    logic             hit;

    always_comb begin
        for (int g = 0; g < int'(GRP_N); g++) begin
            pick[g] = src_i[g*CAND_N + int'(sel_i[g*SEL_W +: SEL_W])];
        end
        hit   = |(pick & en_i);
        aux_o = hit ^ inv_i;
        // R7: an output with nothing enabled shows only its polarity.
        if (en_i == '0) begin
            a_idle_polarity_r7: assert (aux_o == inv_i);
        end
    end

endmodule

// File: rtl/aux_xbar.sv
module aux_xbar
    import axb_pkg::*;
#(
    parameter int unsigned OUT_N = 8,
    parameter int unsigned GRP_N = 32,
    parameter int unsigned DW    = 32,
    parameter logic [GRP_N*CAND_N-1:0] RSVD_MASK =
        (GRP_N*CAND_N)'((128'b1 << 79) | (128'b1 << 87))
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    cfg_we_i,
    input  logic [$clog2(OUT_N)+$clog2(sel_words(GRP_N, DW)+2)-1:0] cfg_addr_i,
    input  logic [DW-1:0]           cfg_wdata_i,
    input  logic [OUT_N-1:0]        clr_i,
    input  logic [GRP_N*CAND_N-1:0] src_i,
    output logic [OUT_N-1:0]        aux_o
);

    localparam int unsigned REG_N = sel_words(GRP_N, DW) + 2;
    localparam int unsigned RAW   = $clog2(REG_N);
    localparam int unsigned OBW   = $clog2(OUT_N);

    logic [OBW-1:0]            wr_out;
    logic [RAW-1:0]            wr_reg;
    logic [GRP_N*CAND_N-1:0]   src_live;

    assign wr_out   = cfg_addr_i[RAW +: OBW];
    assign wr_reg   = cfg_addr_i[RAW-1:0];
    assign src_live = src_i & ~RSVD_MASK;

    for (genvar o = 0; o < int'(OUT_N); o++) begin : g_out
        logic [GRP_N-1:0]       en;
        logic [GRP_N*SEL_W-1:0] sel;
        logic                   inv;
        logic                   wr;

        assign wr = cfg_we_i && (int'(wr_out) == o);

        axb_cfg_bank #(.GRP_N(GRP_N), .DW(DW), .RAW(RAW)) u_bank (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .wr_i    (wr),
            .reg_i   (wr_reg),
            .wdata_i (cfg_wdata_i),
            .clr_i   (clr_i[o]),
            .en_o    (en),
            .sel_o   (sel),
            .inv_o   (inv)
        );

        axb_merge #(.GRP_N(GRP_N)) u_merge (
            .src_i (src_live),
            .en_i  (en),
            .sel_i (sel),
            .inv_i (inv),
            .aux_o (aux_o[o])
        );
    end

    // R1: the cycle after reset every output is low.
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        rst_i |=> (aux_o == '0));

endmodule

// File: tb/aux_xbar_test.sv
module aux_xbar_test;

    logic         clk_i = 1'b0;
    logic         rst_i;
    logic         cfg_we_i;
    logic [4:0]   cfg_addr_i;
    logic [31:0]  cfg_wdata_i;
    logic [7:0]   clr_i;
    logic [127:0] src_i;
    logic [7:0]   aux_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk_i = ~clk_i;

    aux_xbar uut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .clr_i       (clr_i),
        .src_i       (src_i),
        .aux_o       (aux_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Write register r of output o; data lands at the next posedge.
    task automatic wr(input int o, input int r, input logic [31:0] d);
        @(negedge clk_i);
        cfg_we_i    = 1'b1;
        cfg_addr_i  = 5'(o * 4 + r);
        cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse_clr(input int o);
        @(negedge clk_i);
        clr_i[o] = 1'b1;
        @(negedge clk_i);
        clr_i = '0;
    endtask

    task automatic set_src(input logic [127:0] v);
        src_i = v;
        #1;
    endtask

    task automatic t_reset;
        set_src('1);
        for (int o = 0; o < 8; o++) check("R1 reset output", aux_o[o], 1'b0);
        set_src('0);
    endtask

    task automatic t_single;
        wr(0, 0, 32'h0000_0010);       // R2: enable group 4
        wr(0, 1, 32'h0000_0100);       // R3: group 4 -> candidate 1
        set_src(128'b1 << 17);
        check("R3 chosen candidate", aux_o[0], 1'b1);
        set_src(128'b1 << 16);
        check("R3 unchosen candidate", aux_o[0], 1'b0);
        set_src(128'b1 << 17);
        check("R11 same-cycle rise", aux_o[0], 1'b1);
        set_src('0);
        check("R11 same-cycle fall", aux_o[0], 1'b0);
    endtask

    task automatic t_or;
        wr(2, 0, 32'h0010_0001);       // groups 0 and 20
        wr(2, 2, 32'h0000_0200);       // group 20 -> candidate 2 (hi word bits 9:8)
        set_src(128'b1 << 0);
        check("R4 group 0 alone", aux_o[2], 1'b1);
        set_src(128'b1 << 82);
        check("R4 group 20 alone", aux_o[2], 1'b1);
        set_src((128'b1 << 0) | (128'b1 << 82));
        check("R4 both", aux_o[2], 1'b1);
        set_src('0);
        check("R4 none", aux_o[2], 1'b0);
        set_src(128'hF << 20);         // group 5, disabled
        check("R5 disabled group", aux_o[2], 1'b0);
        set_src('0);
    endtask

    task automatic t_invert;
        wr(3, 3, 32'h1);
        check("R7 unconfigured inverted", aux_o[3], 1'b1);
        check("R6 polarity idle", aux_o[3], 1'b1);
        wr(3, 0, 32'h2);               // group 1, candidate 0 = bit 4
        set_src(128'b1 << 4);
        check("R6 inverted active", aux_o[3], 1'b0);
        set_src('0);
    endtask

    task automatic t_clear;
        pulse_clr(0);
        set_src(128'b1 << 17);
        check("R8 cleared output", aux_o[0], 1'b0);
        pulse_clr(3);
        set_src(128'b1 << 4);
        check("R8 invert kept", aux_o[3], 1'b1);
        set_src('0);
        // clear output 2 while writing its enable
        @(negedge clk_i);
        clr_i[2] = 1'b1; cfg_we_i = 1'b1; cfg_addr_i = 5'(2*4 + 0); cfg_wdata_i = 32'h1;
        @(negedge clk_i);
        clr_i = '0; cfg_we_i = 1'b0;
        set_src(128'b1 << 0);
        check("R9 clear beats write", aux_o[2], 1'b0);
        // clear output 2 while writing output 5
        @(negedge clk_i);
        clr_i[2] = 1'b1; cfg_we_i = 1'b1; cfg_addr_i = 5'(5*4 + 0); cfg_wdata_i = 32'h1;
        @(negedge clk_i);
        clr_i = '0; cfg_we_i = 1'b0;
        #1;
        check("R9 other output written", aux_o[5], 1'b1);
        set_src('0);
    endtask

    task automatic t_reserved;
        wr(4, 0, 32'h0008_0000);       // group 19
        wr(4, 2, 32'h0000_00C0);       // group 19 -> candidate 3 (hi bits 7:6)
        set_src(128'b1 << 79);
        check("R10 reserved slot", aux_o[4], 1'b0);
        wr(4, 2, 32'h0000_0080);       // candidate 2
        set_src(128'b1 << 78);
        check("R10 live neighbour", aux_o[4], 1'b1);
        set_src('0);
    endtask

    task automatic t_isolation;
        set_src('1);
        check("R12 output 1 untouched", aux_o[1], 1'b0);
        check("R12 output 7 untouched", aux_o[7], 1'b0);
        set_src('0);
    endtask

    initial begin
        rst_i = 1'b1; cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
        clr_i = '0; src_i = '0;
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        t_reset();
        t_single();
        t_or();
        t_invert();
        t_clear();
        t_reserved();
        t_isolation();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule